// File: doc/BRIEF.md
# Multi-Mode GPIO Port Controller

This block is a register-controlled port of general-purpose pins. Every pin can be moved at run time between four behaviours. It can pass a peripheral's output value and output enable straight to the pad. It can force the pad high or low. It can release the pad so that the pin acts as a high-impedance input. A few pins at the top of the port are plain GPIO pins. They have no peripheral behind them and offer only the three non-functional behaviours.

A small register bus carries the control traffic. It has an address, write data, a write strobe and a registered read data output. Two mode registers hold two bits for each pin. Four set/clear addresses change any group of mode bits in one write, with no read-modify-write. A readback address returns the synchronised level of every pad, whatever mode the pin is in. The pad output value and pad output enable are registered.

Top module: `gpio_mode_port`

## Requirements
- R1: After a synchronous reset, both mode registers are zero, so every pin is hi-Z, pad_oe and pad_out are all zero, and the read data is zero.
- R2: A write to address 0 replaces mode register M0 and a write to address 1 replaces M1. Each leaves the other register unchanged. Reads of addresses 0 and 1 return M0 and M1 one cycle after the address is presented.
- R3: A write to address 2 (M0 set) or address 4 (M1 set) sets each mode bit whose write-data bit is 1 and leaves the others unchanged.
- R4: A write to address 3 (M0 clear) or address 5 (M1 clear) clears each mode bit whose write-data bit is 1 and leaves the others unchanged.
- R5: The pin mode is {M1,M0}. Code 2'b10 drives the pad low (oe=1, out=0) and code 2'b11 drives it high (oe=1, out=1). The pad registers take the new mode one cycle after the mode register changes.
- R6: Code 2'b00 is hi-Z input (oe=0, out=0).
- R7: On a dual-use pin (index below NUM_PINS-NUM_DEDICATED), code 2'b01 copies func_out and func_oe of that pin to pad_out and pad_oe with one register of delay. This applies while the peripheral signals change.
- R8: On a GPIO-only pin (the top NUM_DEDICATED indices), code 2'b01 acts as hi-Z and the peripheral inputs have no effect. Codes 2'b10 and 2'b11 still drive that pin.
- R9: A read of address 6 returns pad_in through a two-flop synchroniser. A pad change made before clock edge k is returned in the read data registered at edge k+2, in any pin mode.
- R10: A write to address 6 or 7 leaves both mode registers unchanged. A read of any address other than 0, 1 and 6 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the register bus |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | NUM_PINS | Write data, one bit per pin |
| reg_rdata | output | NUM_PINS | Registered read data |
| func_out | input | NUM_PINS | Peripheral output value per pin |
| func_oe | input | NUM_PINS | Peripheral output enable per pin |
| pad_in | input | NUM_PINS | Level seen at each pad |
| pad_out | output | NUM_PINS | Registered value driven to each pad |
| pad_oe | output | NUM_PINS | Registered output enable per pad |

## Verification
Bound properties check four things on every cycle. A hi-Z pin never enables its pad. A pin with M1 set always drives the level held in M0. A GPIO-only pin drives only when M1 is set. Set writes and writes to read-only addresses have the required effect on the mode bits. Other behaviour needs directed scenarios run through the scoreboard: the peripheral pass-through values, the clear operations, the read-data muxing with zero for unused addresses, and the exact two-edge latency of the pin-state readback.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] A_MODE_LO = 3'd0;
  localparam logic [REG_ADDR_W-1:0] A_MODE_HI = 3'd1;
  localparam logic [REG_ADDR_W-1:0] A_LO_SET  = 3'd2;
  localparam logic [REG_ADDR_W-1:0] A_LO_CLR  = 3'd3;
  localparam logic [REG_ADDR_W-1:0] A_HI_SET  = 3'd4;
  localparam logic [REG_ADDR_W-1:0] A_HI_CLR  = 3'd5;
  localparam logic [REG_ADDR_W-1:0] A_PINS    = 3'd6;

  // pin mode code is {M1, M0}
  localparam logic [1:0] PM_HIZ  = 2'b00;
  localparam logic [1:0] PM_FUNC = 2'b01;
  localparam logic [1:0] PM_LOW  = 2'b10;
  localparam logic [1:0] PM_HIGH = 2'b11;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 12,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_mode_regs.sv
module gpio_mode_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [NUM_PINS-1:0]   wdata,
  output logic [NUM_PINS-1:0]   mode_lo,
  output logic [NUM_PINS-1:0]   mode_hi
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_lo <= '0;
      mode_hi <= '0;
    end else if (we) begin
      case (addr)
        A_MODE_LO: mode_lo <= wdata;
        A_MODE_HI: mode_hi <= wdata;
        A_LO_SET:  mode_lo <= mode_lo | wdata;
        A_LO_CLR:  mode_lo <= mode_lo & ~wdata;
        A_HI_SET:  mode_hi <= mode_hi | wdata;
        A_HI_CLR:  mode_hi <= mode_hi & ~wdata;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS      = 12,
  parameter int unsigned NUM_DEDICATED = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] mode_lo,
  input  logic [NUM_PINS-1:0] mode_hi,
  input  logic [NUM_PINS-1:0] func_out,
  input  logic [NUM_PINS-1:0] func_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);
  localparam int unsigned FIRST_DED = NUM_PINS - NUM_DEDICATED;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [1:0] code;
    assign code = {mode_hi[i], mode_lo[i]};

    if (i >= FIRST_DED) begin : g_gpio_only
      always_ff @(posedge clk) begin
        if (rst) begin
          pad_out[i] <= 1'b0;
          pad_oe[i]  <= 1'b0;
        end else begin
          case (code)
            PM_LOW:  begin pad_out[i] <= 1'b0; pad_oe[i] <= 1'b1; end
            PM_HIGH: begin pad_out[i] <= 1'b1; pad_oe[i] <= 1'b1; end
            default: begin pad_out[i] <= 1'b0; pad_oe[i] <= 1'b0; end
          endcase
        end
      end
    end else begin : g_dual
      always_ff @(posedge clk) begin
        if (rst) begin
          pad_out[i] <= 1'b0;
          pad_oe[i]  <= 1'b0;
        end else begin
          case (code)
            PM_HIZ:  begin pad_out[i] <= 1'b0;        pad_oe[i] <= 1'b0;       end
            PM_FUNC: begin pad_out[i] <= func_out[i]; pad_oe[i] <= func_oe[i]; end
            PM_LOW:  begin pad_out[i] <= 1'b0;        pad_oe[i] <= 1'b1;       end
            default: begin pad_out[i] <= 1'b1;        pad_oe[i] <= 1'b1;       end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/gpio_mode_port.sv
module gpio_mode_port
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS      = 12,
  parameter int unsigned NUM_DEDICATED = 4,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_we,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [NUM_PINS-1:0]   reg_wdata,
  output logic [NUM_PINS-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0]   func_out,
  input  logic [NUM_PINS-1:0]   func_oe,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   pad_out,
  output logic [NUM_PINS-1:0]   pad_oe
);
  logic [NUM_PINS-1:0] mode_lo;
  logic [NUM_PINS-1:0] mode_hi;
  logic [NUM_PINS-1:0] pin_level;

  gpio_mode_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .mode_lo (mode_lo),
    .mode_hi (mode_hi)
  );

  gpio_pad_mux #(
    .NUM_PINS      (NUM_PINS),
    .NUM_DEDICATED (NUM_DEDICATED)
  ) u_mux (
    .clk      (clk),
    .rst      (rst),
    .mode_lo  (mode_lo),
    .mode_hi  (mode_hi),
    .func_out (func_out),
    .func_oe  (func_oe),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pad_in),
    .dout (pin_level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        A_MODE_LO: reg_rdata <= mode_lo;
        A_MODE_HI: reg_rdata <= mode_hi;
        A_PINS:    reg_rdata <= pin_level;
        default:   reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_mode_port_chk.sv
module gpio_mode_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS      = 12,
  parameter int unsigned NUM_DEDICATED = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  we,
  input logic [REG_ADDR_W-1:0] addr,
  input logic [NUM_PINS-1:0]   wdata,
  input logic [NUM_PINS-1:0]   m0,
  input logic [NUM_PINS-1:0]   m1,
  input logic [NUM_PINS-1:0]   pad_out,
  input logic [NUM_PINS-1:0]   pad_oe
);
  localparam int unsigned FIRST_DED = NUM_PINS - NUM_DEDICATED;
  localparam logic [NUM_PINS-1:0] DED_MASK = ~({NUM_PINS{1'b1}} >> NUM_DEDICATED);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pad_oe == '0 && pad_out == '0));

  assert_hiz_no_drive_R6: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & $past(~m0 & ~m1)) == '0);

  assert_forced_level_R5: assert property (@(posedge clk) disable iff (rst)
    ((($past(m1) & ~pad_oe) == '0) && (((pad_out ^ $past(m0)) & $past(m1)) == '0)));

  assert_gpio_only_drive_R8: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & DED_MASK & ~$past(m1)) == '0);

  assert_lo_set_R3: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_LO_SET) |=> ((m0 & $past(wdata)) == $past(wdata)));

  assert_ro_write_R10: assert property (@(posedge clk) disable iff (rst)
    (we && addr == A_PINS) |=> ($stable(m0) && $stable(m1)));

  initial assert (FIRST_DED <= NUM_PINS);
endmodule

bind gpio_mode_port gpio_mode_port_chk #(
  .NUM_PINS      (NUM_PINS),
  .NUM_DEDICATED (NUM_DEDICATED)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .we      (reg_we),
  .addr    (reg_addr),
  .wdata   (reg_wdata),
  .m0      (mode_lo),
  .m1      (mode_hi),
  .pad_out (pad_out),
  .pad_oe  (pad_oe)
);

// File: tb/tb_gpio_mode_port.sv
`timescale 1ns/1ps
module tb_gpio_mode_port;
  localparam int unsigned N = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_we = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic [N-1:0] func_out = '0;
  logic [N-1:0] func_oe = '0;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_out;
  logic [N-1:0] pad_oe;

  always #4 clk = ~clk;

  gpio_mode_port #(.NUM_PINS(N), .NUM_DEDICATED(4)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .func_out(func_out),
    .func_oe(func_oe), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  typedef struct {
    int           kind;   // 0 rdata, 1 pad_out, 2 pad_oe
    logic [N-1:0] exp;
    string        req;
  } item_t;

  item_t sb[$];
  int    checks = 0;
  int    errors = 0;
  bit    mon_req = 1'b0;
  bit    cap_q = 1'b0;
  bit    done = 1'b0;

  always @(posedge clk) cap_q <= mon_req;

  always @(negedge clk) begin
    if (cap_q && !done && sb.size() > 0) begin
      item_t it;
      logic [N-1:0] act;
      it = sb.pop_front();
      case (it.kind)
        0:       act = reg_rdata;
        1:       act = pad_out;
        default: act = pad_oe;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic expect_item(input int kind, input logic [2:0] a,
                             input logic [N-1:0] e, input string req);
    item_t it;
    it.kind = kind; it.exp = e; it.req = req;
    if (kind == 0) reg_addr = a;
    sb.push_back(it);
    mon_req = 1'b1;
    @(posedge clk); @(negedge clk);
    mon_req = 1'b0;
  endtask

  task automatic expect_pads(input logic [N-1:0] e_out, input logic [N-1:0] e_oe,
                             input string req);
    expect_item(1, 3'd0, e_out, req);
    expect_item(2, 3'd0, e_oe, req);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    expect_item(0, 3'd0, 12'h000, "R1 mode_lo after reset");
    expect_item(0, 3'd1, 12'h000, "R1 mode_hi after reset");
    expect_pads(12'h000, 12'h000, "R1 pads after reset");

    func_out = 12'h0AA;
    func_oe  = 12'h0F0;

    // R2 direct write
    wr(3'd0, 12'h0F0);
    expect_item(0, 3'd0, 12'h0F0, "R2 mode_lo written");
    expect_item(0, 3'd1, 12'h000, "R2 mode_hi untouched");

    // R3 M1 set: pins 0-3 drive low, pins 4-7 functional
    wr(3'd4, 12'h00F);
    expect_pads(12'h0A0, 12'h0FF, "R5 R7 low drive and pass-through");
    expect_item(0, 3'd1, 12'h00F, "R3 mode_hi set");

    // R3 M0 set: pins 0,1 drive high
    wr(3'd2, 12'h003);
    expect_pads(12'h0A3, 12'h0FF, "R3 R5 high drive");

    // R4 M1 clear: pin 0 becomes functional
    wr(3'd5, 12'h001);
    expect_pads(12'h0A2, 12'h0FE, "R4 R7 pin0 functional");
    expect_item(0, 3'd1, 12'h00E, "R4 mode_hi clear");

    // R4 M0 clear: pins 4,5 hi-Z
    wr(3'd3, 12'h030);
    expect_pads(12'h082, 12'h0CE, "R4 R6 pins4-5 hi-Z");
    expect_item(0, 3'd0, 12'h0C3, "R4 mode_lo clear");

    // R8 GPIO-only pins ignore functional code
    func_out = 12'hFAA;
    func_oe  = 12'hFF0;
    wr(3'd2, 12'hF00);
    expect_pads(12'h082, 12'h0CE, "R8 functional code is hi-Z on GPIO-only");
    wr(3'd4, 12'h300);
    expect_pads(12'h382, 12'h3CE, "R8 GPIO-only drive high");

    // R9 pin readback and latency
    pad_in = 12'hA5C;
    repeat (3) @(negedge clk);
    expect_item(0, 3'd6, 12'hA5C, "R9 pin level");
    pad_in = 12'h123;
    expect_item(0, 3'd6, 12'hA5C, "R9 latency edge1");
    expect_item(0, 3'd6, 12'hA5C, "R9 latency edge2");
    expect_item(0, 3'd6, 12'h123, "R9 latency edge3");

    // R10 read-only and unused addresses
    wr(3'd6, 12'hFFF);
    wr(3'd7, 12'hFFF);
    expect_item(0, 3'd0, 12'hFC3, "R10 mode_lo after ro write");
    expect_item(0, 3'd1, 12'h30E, "R10 mode_hi after ro write");
    expect_item(0, 3'd2, 12'h000, "R10 set address reads zero");
    expect_item(0, 3'd7, 12'h000, "R10 unused address reads zero");

    // R7 peripheral change while functional
    func_out = 12'h02A;
    expect_pads(12'h302, 12'h3CE, "R7 pass-through follows peripheral");

    repeat (2) @(negedge clk);
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left=%0d expected=0", sb.size());
    end
    finish_run();
  end
endmodule